// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block joins two eight-bit buses, called side A and side B, and moves a data byte plus one parity bit between them in either direction. Each side has its own capture register with its own load enable. The word it holds is presented on the opposite side, gated by that direction's active-low output enable. The bus pins are split into separate input, output and drive-enable ports, so that pad cells placed around the block can form the bidirectional lines.

The parity bit sent to the destination side comes from one of two sources. In generate mode it is computed from the held byte, with even or odd polarity. In feed-through mode it is the held parity bit, passed on unchanged. In both modes, each side compares the parity computed from its own held byte with its own held parity bit, and pulls an active-low error flag when they disagree. If both output enables are asserted at once, the block drives neither side and raises a contention output.

Top module: `ptx_transceiver`

## Requirements
- R1: While a side's load enable is high at a rising clock edge, that side's data and parity inputs are captured, and they appear on the opposite side's outputs from the next cycle on.
- R2: While a side's load enable is low, its held word does not change, whatever the inputs do.
- R3: In generate mode (`feed_thru_i` = 0), the outgoing parity equals the XOR of the eight held data bits when `odd_sel_i` = 0 (even parity), and its inverse when `odd_sel_i` = 1 (odd parity).
- R4: In feed-through mode (`feed_thru_i` = 1), the outgoing parity equals the held parity bit of the source side.
- R5: `a_err_n_o` / `b_err_n_o` are 0 exactly when the parity computed (per R3 polarity) from that side's held byte differs from that side's held parity bit, in both generate and feed-through modes.
- R6: Side B is driven (`b_oe_o` = 1) only when `ab_oe_n_i` = 0 and `ba_oe_n_i` = 1. Side A is driven (`a_oe_o` = 1) only when `ba_oe_n_i` = 0 and `ab_oe_n_i` = 1.
- R7: When `ab_oe_n_i` and `ba_oe_n_i` are both 0, `oe_conflict_o` = 1 and neither side is driven. Otherwise `oe_conflict_o` = 0.
- R8: A side's data and parity outputs read all zero whenever that side is not driven.
- R9: A synchronous active-high reset clears both held words to zero (data 0, parity 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_data_i | input | 8 | Data received from side A |
| a_par_i | input | 1 | Parity received from side A |
| b_data_i | input | 8 | Data received from side B |
| b_par_i | input | 1 | Parity received from side B |
| odd_sel_i | input | 1 | Parity polarity: 0 even, 1 odd |
| feed_thru_i | input | 1 | Parity source: 0 generate, 1 feed-through |
| a_le_i | input | 1 | Load enable of side A's capture register |
| b_le_i | input | 1 | Load enable of side B's capture register |
| ab_oe_n_i | input | 1 | Active-low enable for driving side B |
| ba_oe_n_i | input | 1 | Active-low enable for driving side A |
| a_data_o | output | 8 | Data driven toward side A |
| a_par_o | output | 1 | Parity driven toward side A |
| a_oe_o | output | 1 | Drive enable for side A |
| b_data_o | output | 8 | Data driven toward side B |
| b_par_o | output | 1 | Parity driven toward side B |
| b_oe_o | output | 1 | Drive enable for side B |
| a_err_n_o | output | 1 | Active-low parity error for side A's held word |
| b_err_n_o | output | 1 | Active-low parity error for side B's held word |
| oe_conflict_o | output | 1 | Both output enables asserted |

## Verification
The hardest case to reach from the ports is a parity error seen in feed-through mode. The held word has to carry a deliberately wrong parity bit, and the outgoing parity must still show that wrong bit unchanged while the error flag drops. The stimulus table loads such words with the load enables held high, then switches feed-through and polarity on later rows while the enables are low, so that a single held word is judged under both polarities. Reset is pulsed over a loaded word so that the cleared state can be told apart from the previous contents.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int DATA_W = 8;
    localparam int SIDES  = 2;
    localparam int SIDE_A = 0;
    localparam int SIDE_B = 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par;
    } bus_word_t;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_pol_e;

    typedef enum logic {
        MODE_GEN  = 1'b0,
        MODE_FEED = 1'b1
    } par_mode_e;

    // Parity bit that makes the word total match the chosen polarity
    function automatic logic calc_par(input logic [DATA_W-1:0] d, input par_pol_e pol);
        return (^d) ^ (pol == PAR_ODD);
    endfunction

endpackage

// File: rtl/ptx_hold_lane.sv
module ptx_hold_lane
    import ptx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      le,
    input  bus_word_t word_i,
    input  par_pol_e  pol,
    output bus_word_t word_q,
    output logic      err_n
);

    bus_word_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (le) begin
            held_q <= word_i;
        end
    end

    assign word_q = held_q;
    assign err_n  = (calc_par(held_q.data, pol) == held_q.par);

endmodule

// File: rtl/ptx_out_stage.sv
module ptx_out_stage
    import ptx_pkg::*;
(
    input  bus_word_t src,
    input  par_pol_e  pol,
    input  par_mode_e mode,
    input  logic      en,
    output bus_word_t word_o,
    output logic      drive_o
);

    always_comb begin
        word_o = '0;
        if (en) begin
            word_o.data = src.data;
            word_o.par  = (mode == MODE_FEED) ? src.par : calc_par(src.data, pol);
        end
    end

    assign drive_o = en;

endmodule

// File: rtl/ptx_transceiver.sv
module ptx_transceiver
    import ptx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_data_i,
    input  logic              a_par_i,
    input  logic [DATA_W-1:0] b_data_i,
    input  logic              b_par_i,
    input  logic              odd_sel_i,
    input  logic              feed_thru_i,
    input  logic              a_le_i,
    input  logic              b_le_i,
    input  logic              ab_oe_n_i,
    input  logic              ba_oe_n_i,
    output logic [DATA_W-1:0] a_data_o,
    output logic              a_par_o,
    output logic              a_oe_o,
    output logic [DATA_W-1:0] b_data_o,
    output logic              b_par_o,
    output logic              b_oe_o,
    output logic              a_err_n_o,
    output logic              b_err_n_o,
    output logic              oe_conflict_o
);

    par_pol_e  pol;
    par_mode_e mode;
    bus_word_t in_word  [SIDES];
    bus_word_t lat_word [SIDES];
    bus_word_t out_word [SIDES];
    logic [SIDES-1:0] le_vec;
    logic [SIDES-1:0] en_vec;
    logic [SIDES-1:0] drv_vec;
    logic [SIDES-1:0] err_vec;
    bus_word_t lat_a_w;
    bus_word_t lat_b_w;

    assign pol  = par_pol_e'(odd_sel_i);
    assign mode = par_mode_e'(feed_thru_i);

    always_comb begin
        in_word[SIDE_A] = '{data: a_data_i, par: a_par_i};
        in_word[SIDE_B] = '{data: b_data_i, par: b_par_i};
        le_vec[SIDE_A]  = a_le_i;
        le_vec[SIDE_B]  = b_le_i;
        // a side is driven only when its own enable is the sole one asserted
        en_vec[SIDE_B]  = !ab_oe_n_i && ba_oe_n_i;
        en_vec[SIDE_A]  = !ba_oe_n_i && ab_oe_n_i;
    end

    assign oe_conflict_o = !ab_oe_n_i && !ba_oe_n_i;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        ptx_hold_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .le     (le_vec[s]),
            .word_i (in_word[s]),
            .pol    (pol),
            .word_q (lat_word[s]),
            .err_n  (err_vec[s])
        );

        // destination side s is fed from the opposite side's register
        ptx_out_stage u_out (
            .src     (lat_word[SIDES-1-s]),
            .pol     (pol),
            .mode    (mode),
            .en      (en_vec[s]),
            .word_o  (out_word[s]),
            .drive_o (drv_vec[s])
        );
    end

    assign lat_a_w   = lat_word[SIDE_A];
    assign lat_b_w   = lat_word[SIDE_B];

    assign a_data_o  = out_word[SIDE_A].data;
    assign a_par_o   = out_word[SIDE_A].par;
    assign a_oe_o    = drv_vec[SIDE_A];
    assign b_data_o  = out_word[SIDE_B].data;
    assign b_par_o   = out_word[SIDE_B].par;
    assign b_oe_o    = drv_vec[SIDE_B];
    assign a_err_n_o = err_vec[SIDE_A];
    assign b_err_n_o = err_vec[SIDE_B];

endmodule

// File: rtl/ptx_checker.sv
module ptx_checker
    import ptx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] a_data_i,
    input logic              a_par_i,
    input logic              a_le_i,
    input logic              b_le_i,
    input logic              feed_thru_i,
    input logic              ab_oe_n_i,
    input logic              ba_oe_n_i,
    input bus_word_t         lat_a,
    input bus_word_t         lat_b,
    input logic [DATA_W-1:0] a_data_o,
    input logic              a_par_o,
    input logic              a_oe_o,
    input logic [DATA_W-1:0] b_data_o,
    input logic              b_par_o,
    input logic              b_oe_o,
    input logic              a_err_n_o,
    input logic              oe_conflict_o
);

    a_r1_capture: assert property (@(posedge clk) disable iff (rst)
        a_le_i |=> (lat_a.data == $past(a_data_i)) && (lat_a.par == $past(a_par_i)));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !b_le_i |=> $stable(lat_b));

    a_r4_feed_par: assert property (@(posedge clk) disable iff (rst)
        (b_oe_o && feed_thru_i) |-> (b_par_o == lat_a.par));

    a_r5_err_vs_gen: assert property (@(posedge clk) disable iff (rst)
        (b_oe_o && !feed_thru_i) |-> (a_err_n_o == (b_par_o == lat_a.par)));

    a_r6_single_drive: assert property (@(posedge clk) disable iff (rst)
        !(a_oe_o && b_oe_o));

    a_r7_conflict: assert property (@(posedge clk) disable iff (rst)
        oe_conflict_o |-> (!a_oe_o && !b_oe_o && !ab_oe_n_i && !ba_oe_n_i));

    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        !a_oe_o |-> (a_data_o == '0 && !a_par_o));

    a_r9_cleared: assert property (@(posedge clk)
        rst |=> (lat_a == '0 && lat_b == '0));

endmodule

bind ptx_transceiver ptx_checker chk_i (
    .clk           (clk),
    .rst           (rst),
    .a_data_i      (a_data_i),
    .a_par_i       (a_par_i),
    .a_le_i        (a_le_i),
    .b_le_i        (b_le_i),
    .feed_thru_i   (feed_thru_i),
    .ab_oe_n_i     (ab_oe_n_i),
    .ba_oe_n_i     (ba_oe_n_i),
    .lat_a         (lat_a_w),
    .lat_b         (lat_b_w),
    .a_data_o      (a_data_o),
    .a_par_o       (a_par_o),
    .a_oe_o        (a_oe_o),
    .b_data_o      (b_data_o),
    .b_par_o       (b_par_o),
    .b_oe_o        (b_oe_o),
    .a_err_n_o     (a_err_n_o),
    .oe_conflict_o (oe_conflict_o)
);

// File: tb/ptx_transceiver_tb_top.sv
`timescale 1ns/1ps
module ptx_transceiver_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] a_data_i, b_data_i;
    logic       a_par_i, b_par_i, odd_sel_i, feed_thru_i;
    logic       a_le_i, b_le_i, ab_oe_n_i, ba_oe_n_i;
    logic [7:0] a_data_o, b_data_o;
    logic       a_par_o, a_oe_o, b_par_o, b_oe_o;
    logic       a_err_n_o, b_err_n_o, oe_conflict_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // bench model of the two held words
    logic [7:0] m_ad, m_bd;
    logic       m_ap, m_bp;

    always #2.5 clk = ~clk;

    ptx_transceiver dut_i (
        .clk(clk), .rst(rst),
        .a_data_i(a_data_i), .a_par_i(a_par_i),
        .b_data_i(b_data_i), .b_par_i(b_par_i),
        .odd_sel_i(odd_sel_i), .feed_thru_i(feed_thru_i),
        .a_le_i(a_le_i), .b_le_i(b_le_i),
        .ab_oe_n_i(ab_oe_n_i), .ba_oe_n_i(ba_oe_n_i),
        .a_data_o(a_data_o), .a_par_o(a_par_o), .a_oe_o(a_oe_o),
        .b_data_o(b_data_o), .b_par_o(b_par_o), .b_oe_o(b_oe_o),
        .a_err_n_o(a_err_n_o), .b_err_n_o(b_err_n_o),
        .oe_conflict_o(oe_conflict_o)
    );

    typedef struct packed {
        logic [7:0] ad; logic ap;
        logic [7:0] bd; logic bp;
        logic odd; logic feed; logic ale; logic ble; logic abn; logic ban;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'hA5,1'b0,8'h3C,1'b0, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 4'd1},
        '{8'h5A,1'b1,8'h3C,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 4'd5},
        '{8'h07,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 4'd3},
        '{8'h07,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 4'd3},
        '{8'h0F,1'b1,8'h00,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd4},
        '{8'h0F,1'b0,8'h00,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd4},
        '{8'h11,1'b0,8'h81,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 4'd6},
        '{8'h11,1'b0,8'h80,1'b1, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 4'd6},
        '{8'hFF,1'b1,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 4'd2},
        '{8'hFF,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 4'd7},
        '{8'h33,1'b0,8'h44,1'b0, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 4'd8},
        '{8'hC3,1'b1,8'h3C,1'b1, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 4'd5},
        '{8'h01,1'b0,8'h02,1'b0, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b1, 4'd5},
        '{8'hFE,1'b0,8'hFE,1'b0, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 4'd3}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic gp(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // {a_oe, a_data, a_par, b_oe, b_data, b_par, a_err_n, b_err_n, conflict}
    function automatic logic [22:0] expect_pack(input logic odd, input logic feed,
                                                input logic abn, input logic ban);
        logic en_b, en_a;
        logic [7:0] ed_a, ed_b;
        logic ep_a, ep_b;
        en_b = !abn && ban;
        en_a = !ban && abn;
        ed_b = en_b ? m_ad : 8'h00;
        ep_b = en_b ? (feed ? m_ap : gp(m_ad, odd)) : 1'b0;
        ed_a = en_a ? m_bd : 8'h00;
        ep_a = en_a ? (feed ? m_bp : gp(m_bd, odd)) : 1'b0;
        return {en_a, ed_a, ep_a, en_b, ed_b, ep_b,
                gp(m_ad, odd) == m_ap, gp(m_bd, odd) == m_bp, !abn && !ban};
    endfunction

    function automatic logic [22:0] actual_pack();
        return {a_oe_o, a_data_o, a_par_o, b_oe_o, b_data_o, b_par_o,
                a_err_n_o, b_err_n_o, oe_conflict_o};
    endfunction

    task automatic check(input string tag, input logic [22:0] act, input logic [22:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive_vec(input vec_t v);
        a_data_i = v.ad; a_par_i = v.ap; b_data_i = v.bd; b_par_i = v.bp;
        odd_sel_i = v.odd; feed_thru_i = v.feed;
        a_le_i = v.ale; b_le_i = v.ble; ab_oe_n_i = v.abn; ba_oe_n_i = v.ban;
        if (v.ale) begin m_ad = v.ad; m_ap = v.ap; end
        if (v.ble) begin m_bd = v.bd; m_bp = v.bp; end
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive_vec('{8'h00,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 4'd9});
        m_ad = 8'h00; m_ap = 1'b0; m_bd = 8'h00; m_bp = 1'b0;
        repeat (3) @(negedge clk);
        // R9: cleared words, B driven with zero data and even parity 0
        check("R9", actual_pack(), expect_pack(1'b0, 1'b0, 1'b0, 1'b1));
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive_vec(VECS[i]);
            @(negedge clk);
            check(tag_name(VECS[i].tag), actual_pack(),
                  expect_pack(VECS[i].odd, VECS[i].feed, VECS[i].abn, VECS[i].ban));
        end

        // R9: reset over a loaded word clears it
        drive_vec('{8'hE7,1'b1,8'h7E,1'b1, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 4'd9});
        @(negedge clk);
        rst = 1'b1;
        a_le_i = 1'b0; b_le_i = 1'b0;
        m_ad = 8'h00; m_ap = 1'b0; m_bd = 8'h00; m_bp = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check("R9", actual_pack(), expect_pack(1'b0, 1'b0, 1'b0, 1'b1));

        // R2: inputs toggle for several cycles with the load enable low
        a_data_i = 8'h96; a_par_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", actual_pack(), expect_pack(1'b0, 1'b0, 1'b0, 1'b1));

        // R1: a single load pulse, then the word stays
        a_le_i = 1'b1; m_ad = 8'h96; m_ap = 1'b1;
        @(negedge clk);
        a_le_i = 1'b0; a_data_i = 8'h00;
        check("R1", actual_pack(), expect_pack(1'b0, 1'b0, 1'b0, 1'b1));
        @(negedge clk);
        // R5: 0x96 has four ones, so parity 1 is an error under even polarity
        check("R5", actual_pack(), expect_pack(1'b0, 1'b0, 1'b0, 1'b1));
        odd_sel_i = 1'b1;
        #1;
        // R3: polarity change alone flips the generated parity and the error flag
        check("R3", actual_pack(), expect_pack(1'b1, 1'b0, 1'b0, 1'b1));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule